// File: doc/BRIEF.md
# Two-Button Serial Passcode Lock

This block is the control unit for a lock whose passcode is keyed in one binary digit at a time. Two push buttons feed it: one enters a 1 and the other enters a 0. Each raw button line goes through a synchroniser and a rising-edge detector. A press therefore advances the entry by exactly one digit, however long the button is held.

Once the fourth digit is in, the block raises either the pass output or the fail output. It keeps that result until the asynchronous reset is applied. A wrong digit does not end the entry early. The block notes the mismatch, keeps counting the remaining presses, and reports failure only when the last digit arrives. Contact debouncing is not part of this block, so presses are expected to be clean.

Top module: `serial_code_lock`

## Requirements
- R1: With the default code 1,0,1,0 (the first digit entered is the most significant bit of parameter CODE = 4'b1010), entering exactly those four digits drives pass_o high and fail_o low.
- R2: Entering four digits where at least one digit differs from the code drives fail_o high and pass_o low.
- R3: Neither pass_o nor fail_o is high while fewer than four digits have been entered.
- R4: After a wrong digit the lock still counts the remaining presses, and fail_o rises only on the fourth press, never earlier.
- R5: Once a result is showing, it stays unchanged through any further presses until reset.
- R6: A press is counted once however long the button stays high. The resulting output change shows after the third rising clock edge that follows the raw input going high.
- R7: If both buttons produce their press event in the same clock cycle, the event is ignored and the digit count does not change.
- R8: Clock cycles with no press leave the entry state unchanged, however many of them pass.
- R9: Asserting rst_n low returns the lock to its start state, with pass_o and fail_o low and no digits counted.
- R10: pass_o and fail_o are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_one_i | input | 1 | Raw button that enters a 1 digit |
| key_zero_i | input | 1 | Raw button that enters a 0 digit |
| pass_o | output | 1 | High once all digits entered match the code |
| fail_o | output | 1 | High once all digits are entered and any one mismatched |

## Verification
A raw press rising between clock edges passes two synchroniser flops and the edge flop, so its digit updates the state on the third rising edge after the rise, and the result outputs follow that edge combinationally. The bench drives every input on a falling edge. For the final digit it samples the outputs on the falling edge after the second rising edge, where the result must still be absent, and again after the third, where it must have appeared. All other checks sample only after the press has been released and several idle cycles have passed, so each digit has fully settled.

// File: rtl/lock_pkg.sv
package lock_pkg;

  typedef enum logic [1:0] {
    KEY_NONE  = 2'd0,
    KEY_ZERO  = 2'd1,
    KEY_ONE   = 2'd2,
    KEY_CLASH = 2'd3
  } key_e;

  // Turn two press pulses into one key event; simultaneous pulses clash.
  function automatic key_e classify_keys(input logic one_p, input logic zero_p);
    if (one_p && zero_p) return KEY_CLASH;
    if (one_p)           return KEY_ONE;
    if (zero_p)          return KEY_ZERO;
    return KEY_NONE;
  endfunction

  // Digit expected at entry position pos; the first entry is the MSB of code.
  function automatic logic expected_digit(input logic [31:0] code,
                                          input int unsigned len,
                                          input int unsigned pos);
    return code[len - 1 - pos];
  endfunction

endpackage

// File: rtl/btn_sync_edge.sv
module btn_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  // STAGES synchroniser flops plus one flop holding the previous level.
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], raw_i};
  end

  logic level_now, level_prev;
  assign level_now  = chain_q[STAGES-1];
  assign level_prev = chain_q[STAGES];
  assign rise_o     = level_now & ~level_prev;

endmodule

// File: rtl/code_fsm.sv
module code_fsm
  import lock_pkg::*;
#(
  parameter int          CODE_LEN = 4,
  parameter logic [31:0] CODE     = 32'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic one_p_i,
  input  logic zero_p_i,
  output logic pass_o,
  output logic fail_o
);
  localparam int CW = $clog2(CODE_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(CODE_LEN);

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic          miss;
  } entry_t;

  entry_t cur_q, nxt;
  key_e   key;
  logic   done, take, digit, want;

  assign key   = classify_keys(one_p_i, zero_p_i);
  assign done  = (cur_q.cnt == LAST);
  assign take  = (key == KEY_ONE) || (key == KEY_ZERO);
  assign digit = (key == KEY_ONE);
  assign want  = expected_digit(CODE, CODE_LEN, 32'(cur_q.cnt));

  always_comb begin
    nxt = cur_q;
    if (cur_q.cnt > LAST) begin
      nxt = '0;
    end else if (!done && take) begin
      nxt.cnt  = cur_q.cnt + 1'b1;
      nxt.miss = cur_q.miss | (digit != want);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign pass_o = done & ~cur_q.miss;
  assign fail_o = done &  cur_q.miss;

  // R3
  result_after_last_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o || fail_o) |-> ($past(cur_q.cnt) == LAST - 1'b1));

  // R4
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.miss |=> cur_q.miss);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |=> ($stable(pass_o) && $stable(fail_o)));

  // R7
  clash_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_p_i && zero_p_i) |=> $stable(cur_q.cnt));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_p_i && !zero_p_i) |=> $stable(cur_q));

  // R10
  exclusive_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock #(
  parameter int          CODE_LEN    = 4,
  parameter logic [31:0] CODE        = 32'b1010,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_one_i,
  input  logic key_zero_i,
  output logic pass_o,
  output logic fail_o
);
  localparam int NKEYS = 2;

  logic [NKEYS-1:0] raw_keys;
  logic [NKEYS-1:0] key_rise;

  assign raw_keys = {key_one_i, key_zero_i};

  for (genvar g = 0; g < NKEYS; g++) begin : g_key
    btn_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_keys[g]),
      .rise_o (key_rise[g])
    );
  end

  code_fsm #(.CODE_LEN(CODE_LEN), .CODE(CODE)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .one_p_i  (key_rise[1]),
    .zero_p_i (key_rise[0]),
    .pass_o   (pass_o),
    .fail_o   (fail_o)
  );

endmodule

// File: tb/serial_code_lock_tb.sv
module serial_code_lock_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic k1 = 1'b0, k0 = 1'b0;
  logic pass_o, fail_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_code_lock dut_i (
    .clk(clk), .rst_n(rst_n), .key_one_i(k1), .key_zero_i(k0),
    .pass_o(pass_o), .fail_o(fail_o)
  );

  // exp/act packed as {pass, fail}
  task automatic chk(input string req, input logic [1:0] exp);
    n_chk++;
    if ({pass_o, fail_o} !== exp) begin
      n_bad++;
      $display("FAIL %s: {pass,fail} actual %b expected %b", req, {pass_o, fail_o}, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Press one button (d=1 enters a 1) for hold cycles, then settle.
  task automatic press(input logic d, input int hold);
    @(negedge clk);
    if (d) k1 = 1'b1; else k0 = 1'b1;
    repeat (hold) @(negedge clk);
    k1 = 1'b0; k0 = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Final press with cycle-exact sampling: absent after 2 edges, present after 3.
  task automatic press_timed(input logic d, input logic [1:0] exp, input string req);
    @(negedge clk);
    if (d) k1 = 1'b1; else k0 = 1'b1;
    repeat (2) @(negedge clk);
    chk(req, 2'b00);
    k1 = 1'b0; k0 = 1'b0;
    @(negedge clk);
    chk(req, exp);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 reset state", 2'b00);
  endtask

  task automatic t_correct();
    do_reset();
    press(1, 1); press(0, 1); press(1, 1);
    chk("R3 three digits no result", 2'b00);
    press_timed(0, 2'b10, "R1 R6 pass timing");
    chk("R10 exclusive", 2'b10);
  endtask

  task automatic t_latch_pass();
    press(0, 1); press(1, 1); press(1, 3);
    chk("R5 pass held after presses", 2'b10);
    do_reset();
    chk("R9 reset clears pass", 2'b00);
  endtask

  task automatic t_first_wrong();
    do_reset();
    press(0, 1);
    chk("R4 one wrong digit no result", 2'b00);
    press(0, 1);
    chk("R4 two digits no result", 2'b00);
    press(1, 1);
    chk("R4 three digits no result", 2'b00);
    press_timed(0, 2'b01, "R4 R2 fail on fourth");
    press(1, 1); press(0, 1);
    chk("R5 fail held after presses", 2'b01);
  endtask

  task automatic t_last_wrong();
    do_reset();
    press(1, 1); press(0, 1); press(1, 1); press(1, 1);
    chk("R2 last digit wrong", 2'b01);
  endtask

  task automatic t_held();
    do_reset();
    press(1, 25);
    chk("R6 long press counted once", 2'b00);
    press(0, 1); press(1, 1);
    chk("R6 three digits after long press", 2'b00);
    press(0, 1);
    chk("R6 R1 pass after long press", 2'b10);
  endtask

  task automatic t_both();
    do_reset();
    @(negedge clk); k1 = 1'b1; k0 = 1'b1;
    @(negedge clk); k1 = 1'b0; k0 = 1'b0;
    repeat (4) @(negedge clk);
    press(1, 1); press(0, 1); press(1, 1);
    chk("R7 clash not counted", 2'b00);
    press(0, 1);
    chk("R7 pass after clash", 2'b10);
  endtask

  task automatic t_idle();
    do_reset();
    press(1, 1);
    repeat (60) @(negedge clk);
    press(0, 1);
    repeat (60) @(negedge clk);
    press(1, 1);
    repeat (60) @(negedge clk);
    chk("R8 idle keeps count", 2'b00);
    press(0, 1);
    chk("R8 pass after idle gaps", 2'b10);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_correct();
    t_latch_pass();
    t_first_wrong();
    t_last_wrong();
    t_held();
    t_both();
    t_idle();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule